// File: doc/BRIEF.md
# Four-Decade BCD Counter with Overload Digit

This block counts rising edges of a slow external count signal into four cascaded binary-coded-decimal decades. A fifth element, a single overload bit, extends the range to 0 through 19 999. The count signal is sampled by the system clock through a synchronizer and an edge detector, so every counted edge is handled in one register update. A digit that rolls over from 9 carries into the next digit in that same update.

Two asynchronous override inputs act directly on the state registers. Clear forces the whole state to zero. Preset forces it to full scale. Clear wins over preset, and both win over counting. The raw count state is brought out for a separate readout stage. Four active-low carry flags are decoded from the decades: three flags for runs of nines from the lowest decade upward, and one flag for the overload range. The three nines flags are held inactive while preset is asserted.

The system reset `rst_n` is active low and asynchronous. It is expected to be released synchronously to `clk` by the surrounding chip.

Top module: `bcd_overrange_counter`

## Requirements
- R1: A low-to-high transition of `count_in` adds one to the count while `clear_in` and `preset_in` are both low. The new value appears on `count_state` at the third rising edge of `clk` after the transition is first sampled.
- R2: While `clear_in` is high, `count_state` is zero, whatever `preset_in` and `count_in` are doing.
- R3: While `preset_in` is high and `clear_in` is low, `count_state` holds full scale. Full scale means bit 16 (the overload bit) is 1 and each decade field `count_state[4k+3:4k]` holds 9.
- R4: With `preset_in` low, `carry_n[0]` is low exactly when decades 0 and 1 both hold 9 (for example xx099 or xx199).
- R5: With `preset_in` low, `carry_n[1]` is low exactly when decades 0 to 2 all hold 9. Likewise `carry_n[2]` is low exactly when decades 0 to 3 all hold 9, which happens only at 09 999 and 19 999.
- R6: While `preset_in` is high, `carry_n[2:0]` are all high. Once preset returns low they fall, because the state is then full scale.
- R7: `carry_n[3]` is low exactly when the count is 10 000 or more. That means it goes low on reaching 10 000 and returns high only when the count returns to zero.
- R8: A counted edge at 19 999 wraps the whole state, overload bit included, to 00 000.
- R9: A decade rolls from 9 to 0 and carries into the next decade in the same update. For example, 00 999 goes to 01 000 in one step.
- R10: Two cases leave the count unchanged. A `count_in` held high past its rising edge adds only one. A rising edge that occurs while clear or preset is high adds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| count_in | input | 1 | Asynchronous signal whose rising edges are counted |
| clear_in | input | 1 | Asynchronous clear to zero, active high, highest priority |
| preset_in | input | 1 | Asynchronous preset to 19 999, active high |
| carry_n | output | 4 | Active-low flags: [0] two lowest decades at 9, [1] three, [2] four, [3] overload range |
| count_state | output | 17 | Overload bit at [16], decade k at [4k+3:4k] |

## Verification
The bench builds the block with its default parameters: four decades and a two-flop synchronizer. At that size the full state space of 20 000 values is small. The bench drives one counted edge per step through the entire range and across the wrap. After every step it compares the state and all four carry flags with values derived by plain decimal arithmetic from a reference integer. Focused sequences then cover the three-cycle latency, a held count level, edges during clear and preset, clear-over-preset priority, and the carry mask while preset is high.

// File: rtl/bcdc_pkg.sv
package bcdc_pkg;
  typedef logic [3:0] digit_t;
  localparam digit_t DIGIT_MAX  = 4'd9;
  localparam digit_t DIGIT_ZERO = 4'd0;
endpackage

// File: rtl/bcdc_edge_sync.sv
module bcdc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/bcdc_decade.sv
module bcdc_decade
  import bcdc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr_i,
  input  logic   pre_i,
  input  logic   inc_i,
  output digit_t digit_o,
  output logic   nine_o,
  output logic   carry_o
);
  digit_t digit_q;
  digit_t digit_d;

  assign nine_o  = (digit_q == DIGIT_MAX);
  assign carry_o = inc_i & nine_o;

  always_comb begin
    digit_d = nine_o ? DIGIT_ZERO : digit_q + 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n or posedge clr_i or posedge pre_i) begin
    if (!rst_n) begin
      digit_q <= DIGIT_ZERO;
    end else if (clr_i) begin
      digit_q <= DIGIT_ZERO;
    end else if (pre_i) begin
      digit_q <= DIGIT_MAX;
    end else if (inc_i) begin
      digit_q <= digit_d;
    end
  end

  assign digit_o = digit_q;
endmodule

// File: rtl/bcdc_carry_dec.sv
module bcdc_carry_dec #(
  parameter int NUM_DECADES = 4
) (
  input  logic [NUM_DECADES-1:0] nines_i,
  input  logic                   ovf_i,
  input  logic                   pre_i,
  output logic [NUM_DECADES-1:0] carry_n_o
);
  logic [NUM_DECADES-1:0] run_nines;

  assign run_nines[0] = nines_i[0];

  for (genvar k = 1; k < NUM_DECADES; k++) begin : g_run
    assign run_nines[k] = run_nines[k-1] & nines_i[k];
    assign carry_n_o[k-1] = ~run_nines[k] | pre_i;
  end

  assign carry_n_o[NUM_DECADES-1] = ~ovf_i;
endmodule

// File: rtl/bcd_overrange_counter.sv
module bcd_overrange_counter #(
  parameter int NUM_DECADES = 4,
  parameter int SYNC_STAGES = 2,
  localparam int STATE_W = 4 * NUM_DECADES + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               count_in,
  input  logic               clear_in,
  input  logic               preset_in,
  output logic [NUM_DECADES-1:0] carry_n,
  output logic [STATE_W-1:0] count_state
);
  import bcdc_pkg::*;

  logic                   cnt_rise;
  logic                   cnt_en;
  logic [NUM_DECADES:0]   ripple;
  logic [NUM_DECADES-1:0] nines;
  digit_t                 digits [NUM_DECADES];
  logic                   ovf_q;
  logic                   ovf_d;

  bcdc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (count_in),
    .rise_o  (cnt_rise)
  );

  assign cnt_en    = cnt_rise & ~clear_in & ~preset_in;
  assign ripple[0] = cnt_en;

  for (genvar k = 0; k < NUM_DECADES; k++) begin : g_dec
    bcdc_decade u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clear_in),
      .pre_i   (preset_in),
      .inc_i   (ripple[k]),
      .digit_o (digits[k]),
      .nine_o  (nines[k]),
      .carry_o (ripple[k+1])
    );
    assign count_state[4*k +: 4] = digits[k];
  end

  // overload bit toggles on carry out of the top decade (19 999 -> 0 wraps)
  always_comb begin
    ovf_d = ~ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n or posedge clear_in or posedge preset_in) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else if (clear_in) begin
      ovf_q <= 1'b0;
    end else if (preset_in) begin
      ovf_q <= 1'b1;
    end else if (ripple[NUM_DECADES]) begin
      ovf_q <= ovf_d;
    end
  end

  assign count_state[STATE_W-1] = ovf_q;

  bcdc_carry_dec #(.NUM_DECADES(NUM_DECADES)) u_carry (
    .nines_i   (nines),
    .ovf_i     (ovf_q),
    .pre_i     (preset_in),
    .carry_n_o (carry_n)
  );
endmodule

// File: rtl/bcdc_checker.sv
module bcdc_checker #(
  parameter int NUM_DECADES = 4,
  localparam int STATE_W = 4 * NUM_DECADES + 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   clear_in,
  input logic                   preset_in,
  input logic [NUM_DECADES-1:0] carry_n,
  input logic [STATE_W-1:0]     count_state
);
  function automatic int to_bin(logic [STATE_W-1:0] s);
    int v;
    int w;
    v = 0;
    w = 1;
    for (int k = 0; k < NUM_DECADES; k++) begin
      v = v + w * int'(s[4*k +: 4]);
      w = w * 10;
    end
    if (s[STATE_W-1]) v = v + w;
    return v;
  endfunction

  function automatic int top_val();
    int w;
    w = 1;
    for (int k = 0; k < NUM_DECADES; k++) w = w * 10;
    return w;
  endfunction

  function automatic logic digits_ok(logic [STATE_W-1:0] s);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < NUM_DECADES; k++) if (s[4*k +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  logic quiet;
  assign quiet = !clear_in && !preset_in;

  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    digits_ok(count_state)); // R9

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear_in |-> (count_state == '0)); // R2

  AST_PRESET_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_in && !clear_in) |-> (to_bin(count_state) == 2 * top_val() - 1)); // R3

  AST_PRESET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    preset_in |-> (&carry_n[NUM_DECADES-2:0])); // R6

  AST_LOW_NINES: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset_in && count_state[7:0] == 8'h99) |-> !carry_n[0]); // R4

  AST_OVER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n[NUM_DECADES-1] == (to_bin(count_state) >= top_val())); // R7

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && $past(quiet) && count_state != $past(count_state)) |->
      (to_bin(count_state) == (to_bin($past(count_state)) + 1) % (2 * top_val()))); // R8
endmodule

bind bcd_overrange_counter bcdc_checker #(.NUM_DECADES(NUM_DECADES)) u_bcdc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clear_in    (clear_in),
  .preset_in   (preset_in),
  .carry_n     (carry_n),
  .count_state (count_state)
);

// File: tb/bcd_overrange_counter_bench.sv
module bcd_overrange_counter_bench;
  localparam int ND = 4;
  localparam int SW = 4 * ND + 1;
  localparam int FULL = 19999;

  logic clk;
  logic rst_n;
  logic count_in;
  logic clear_in;
  logic preset_in;
  logic [ND-1:0] carry_n;
  logic [SW-1:0] count_state;

  int n_cmp;
  int n_bad;
  int e;

  bcd_overrange_counter u_bcd_overrange_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .count_in    (count_in),
    .clear_in    (clear_in),
    .preset_in   (preset_in),
    .carry_n     (carry_n),
    .count_state (count_state)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [SW-1:0] exp_state(int v);
    logic [SW-1:0] s;
    s[16]    = (v >= 10000);
    s[3:0]   = 4'(v % 10);
    s[7:4]   = 4'((v / 10) % 10);
    s[11:8]  = 4'((v / 100) % 10);
    s[15:12] = 4'((v / 1000) % 10);
    return s;
  endfunction

  function automatic logic [ND-1:0] exp_carry(int v, logic pre);
    logic [ND-1:0] c;
    c[0] = pre | ((v % 100) != 99);
    c[1] = pre | ((v % 1000) != 999);
    c[2] = pre | ((v % 10000) != 9999);
    c[3] = (v < 10000);
    return c;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic chk_all(string req, int v, logic pre);
    chk(req, 32'(count_state), 32'(exp_state(v)));
    chk(req, 32'(carry_n), 32'(exp_carry(v, pre)));
  endtask

  task automatic pulse();
    count_in = 1'b1;
    repeat (3) @(negedge clk);
    count_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    n_cmp = 0;
    n_bad = 0;
    rst_n = 1'b0;
    count_in = 1'b0;
    clear_in = 1'b0;
    preset_in = 1'b0;
    repeat (3) @(negedge clk);
    chk_all("reset state", 0, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 latency: unchanged after two edges, counted at third
    count_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 no early update", 32'(count_state), 32'(exp_state(0)));
    @(negedge clk);
    chk("R1 third edge update", 32'(count_state), 32'(exp_state(1)));
    // R10 held level adds only one
    repeat (10) @(negedge clk);
    chk("R10 held high", 32'(count_state), 32'(exp_state(1)));
    count_in = 1'b0;
    repeat (3) @(negedge clk);
    e = 1;

    // full sweep through the range and across the wrap: R1 R4 R5 R7 R8 R9
    for (int i = 0; i < 20000; i++) begin
      pulse();
      e = (e + 1) % 20000;
      chk_all("R1/R4/R5/R7/R8/R9 sweep", e, 1'b0);
    end
    chk("R8 wrap landed", 32'(e), 32'd1);

    // preset with carry mask: R3 R6
    preset_in = 1'b1;
    @(negedge clk);
    chk_all("R3 preset full scale", FULL, 1'b1);
    chk("R6 mask while preset", 32'(carry_n[2:0]), 32'h7);
    pulse();
    chk_all("R10 edge during preset", FULL, 1'b1);
    preset_in = 1'b0;
    @(negedge clk);
    chk("R6 carries fall after preset", 32'(carry_n), 32'h0);
    pulse();
    chk_all("R8 wrap from preset", 0, 1'b0);

    // clear priority: R2
    repeat (5) pulse();
    chk_all("R1 counted to five", 5, 1'b0);
    clear_in = 1'b1;
    preset_in = 1'b1;
    @(negedge clk);
    chk_all("R2 clear over preset", 0, 1'b1);
    preset_in = 1'b0;
    pulse();
    chk_all("R2 R10 edge during clear", 0, 1'b0);
    clear_in = 1'b0;
    @(negedge clk);
    pulse();
    chk_all("R1 count after clear", 1, 1'b0);

    // R7 overload flag persists 10000 through 19999
    preset_in = 1'b1;
    @(negedge clk);
    preset_in = 1'b0;
    @(negedge clk);
    chk("R7 overload at full", 32'(carry_n[3]), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule